// File: doc/BRIEF.md
# Four-Channel DMA Control and Status Registers

This block holds the global control state of a four-channel DMA controller: a command register, a status register made of per-channel terminal-count flags and request flags, a four-bit channel mask and one mode byte per channel. A host writes and reads it through a 3-bit control offset, one byte per access. The channel register block, which stores addresses and counts, takes the mask, the request bits, the mode fields and a strobe that clears its byte-order flip-flop. The service engine returns one-cycle terminal-count pulses, which are latched into the status register.

Writes and reads are single-cycle and plain. A write takes effect at the rising edge at which `wr_en` is high. Read data is combinational from the current state while `rd_en` is high. A status read clears the terminal-count flags at that same edge. There is no stream interface and no back-pressure: every access completes in the cycle it is presented.

Top module: `dma_ctl_regs`

## Requirements
- R1: After reset, command is 0, all four mask bits are 1, all status bits are 0 and every mode byte is 0.
- R2: A write at offset 0 loads the command register only when the byte is 0x00 or 0x04. Any other value leaves the command register unchanged.
- R3: A write at offset 1 selects channel c with bits [1:0]. Bit 2 sets (1) or clears (0) that channel's software request, which is status bit c+4. Status bit c (its terminal-count flag) is cleared either way.
- R4: A write at offset 2 selects channel c with bits [1:0] and sets mask bit c to the value of bit 2. The other mask bits keep their values.
- R5: A write at offset 3 stores the whole byte as the mode of the channel named by bits [1:0]. It appears on `mode_o[8c+7:8c]`. Within the byte, bits [3:2] are the transfer type, bit 4 is auto-initialize, bit 5 is address decrement and bits [7:6] are the mode.
- R6: `ff_clear_o` is high during any cycle with a write at offset 4 or offset 5, and low otherwise.
- R7: A write at offset 5 sets all mask bits and clears the command register, the software requests and the terminal-count flags. Mode bytes are kept.
- R8: A write at offset 6 clears all mask bits. A write at offset 7 loads the mask from data bits [3:0].
- R9: A read at offset 0 returns {request bits[7:4], terminal-count bits[3:0]} and clears the terminal-count bits at that edge. A read at offset 1 returns {4'b0, mask}. Reads at all other offsets return 0.
- R10: A pulse on `tc_set[c]` sets terminal-count bit c at that edge. It wins over a clear from a status read or from a request write in the same cycle.
- R11: The request bits, on `req_o` and in status bits [7:4], are the OR of the software requests and the level on `hw_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for `port_ofs` / `wr_data` |
| rd_en | input | 1 | Read strobe for `port_ofs` |
| port_ofs | input | 3 | Control port offset |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte (combinational) |
| tc_set | input | 4 | Terminal-count pulses from the service engine |
| hw_req | input | 4 | Hardware request levels |
| cmd_o | output | 8 | Command register |
| mask_o | output | 4 | Channel mask |
| req_o | output | 4 | Effective request bits |
| mode_o | output | 32 | Four mode bytes, channel 0 in the low byte |
| ff_clear_o | output | 1 | Flip-flop clear strobe |

## Verification
The hardest case to reach is a terminal-count pulse landing in the same cycle as a clear of the same flag, from either a status read or a request write. This is the only place where two sources fight over one bit. Random stimulus makes such pulses sparse and reads frequent, and directed steps line up a pulse with each kind of clear. A reference model in the bench checks the resulting status byte on the next read.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int NCH = 4;
  localparam int CHW = $clog2(NCH);
  localparam int DW  = 8;
  localparam logic [DW-1:0] CMD_ALLOWED = 8'h04;

  typedef enum logic [2:0] {
    OFS_CMD   = 3'd0,
    OFS_REQ   = 3'd1,
    OFS_SMASK = 3'd2,
    OFS_MODE  = 3'd3,
    OFS_FFCLR = 3'd4,
    OFS_MRST  = 3'd5,
    OFS_MCLR  = 3'd6,
    OFS_MWR   = 3'd7
  } ctl_ofs_e;
endpackage

// File: rtl/dma_cmd_mask.sv
module dma_cmd_mask
  import dma_ctl_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  ctl_ofs_e       ofs,
  input  logic [DW-1:0]  wr_data,
  output logic [DW-1:0]  cmd_o,
  output logic [NCH-1:0] mask_o
);
  logic [DW-1:0]  cmd_q;
  logic [NCH-1:0] mask_q;
  logic [CHW-1:0] sel;
  logic           cmd_ok;

  assign sel    = wr_data[CHW-1:0];
  assign cmd_ok = (wr_data & ~CMD_ALLOWED) == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      mask_q <= '1;
    end else if (wr_en) begin
      case (ofs)
        OFS_CMD:   if (cmd_ok) cmd_q <= wr_data;
        OFS_SMASK: mask_q[sel] <= wr_data[CHW];
        OFS_MRST: begin
          cmd_q  <= '0;
          mask_q <= '1;
        end
        OFS_MCLR:  mask_q <= '0;
        OFS_MWR:   mask_q <= wr_data[NCH-1:0];
        default: ;
      endcase
    end
  end

  assign cmd_o  = cmd_q;
  assign mask_o = mask_q;

  // R2
  cmd_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ofs == OFS_CMD && (wr_data & ~CMD_ALLOWED) != '0) |=> $stable(cmd_q));
  // R7
  master_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ofs == OFS_MRST) |=> (mask_q == '1 && cmd_q == '0));
  // R4
  single_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ofs == OFS_SMASK) |=>
      (((mask_q >> $past(wr_data[CHW-1:0])) & 1) == NCH'($past(wr_data[CHW]))));
endmodule

// File: rtl/dma_status_reg.sv
module dma_status_reg
  import dma_ctl_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           rd_en,
  input  ctl_ofs_e       ofs,
  input  logic [DW-1:0]  wr_data,
  input  logic [NCH-1:0] tc_set,
  input  logic [NCH-1:0] hw_req,
  output logic [NCH-1:0] tc_o,
  output logic [NCH-1:0] req_o
);
  logic [NCH-1:0] tc_q, sw_q, tc_clr, sw_d;
  logic [CHW-1:0] sel;

  assign sel = wr_data[CHW-1:0];

  always_comb begin
    tc_clr = '0;
    sw_d   = sw_q;
    if (rd_en && ofs == OFS_CMD) tc_clr = '1;
    if (wr_en) begin
      case (ofs)
        OFS_REQ: begin
          tc_clr[sel] = 1'b1;
          sw_d[sel]   = wr_data[CHW];
        end
        OFS_MRST: begin
          tc_clr = '1;
          sw_d   = '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q <= '0;
      sw_q <= '0;
    end else begin
      tc_q <= (tc_q & ~tc_clr) | tc_set;
      sw_q <= sw_d;
    end
  end

  assign tc_o  = tc_q;
  assign req_o = sw_q | hw_req;

  // R10
  tc_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_set != '0) |=> ((tc_q & $past(tc_set)) == $past(tc_set)));
  // R9
  status_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ofs == OFS_CMD && tc_set == '0) |=> (tc_q == '0));
  // R11
  hw_req_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_o & hw_req) == hw_req));
endmodule

// File: rtl/dma_mode_bank.sv
module dma_mode_bank
  import dma_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  ctl_ofs_e          ofs,
  input  logic [DW-1:0]     wr_data,
  output logic [NCH*DW-1:0] mode_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0] mode_q;
    logic          hit;
    assign hit = wr_en && ofs == OFS_MODE && wr_data[CHW-1:0] == CHW'(c);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mode_q <= '0;
      else if (hit) mode_q <= wr_data;
    end

    assign mode_o[c*DW +: DW] = mode_q;

    // R5
    mode_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ofs == OFS_MODE && wr_data[CHW-1:0] == CHW'(c)) |=>
        (mode_o[c*DW +: DW] == $past(wr_data)));
  end
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  port_ofs,
  input  logic [7:0]  wr_data,
  output logic [7:0]  rd_data,
  input  logic [3:0]  tc_set,
  input  logic [3:0]  hw_req,
  output logic [7:0]  cmd_o,
  output logic [3:0]  mask_o,
  output logic [3:0]  req_o,
  output logic [31:0] mode_o,
  output logic        ff_clear_o
);
  ctl_ofs_e       ofs;
  logic [NCH-1:0] tc_w, req_w, mask_w;

  assign ofs = ctl_ofs_e'(port_ofs);

  dma_cmd_mask u_cmd_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ofs(ofs), .wr_data(wr_data),
    .cmd_o(cmd_o), .mask_o(mask_w)
  );

  dma_status_reg u_status (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .ofs(ofs),
    .wr_data(wr_data), .tc_set(tc_set), .hw_req(hw_req),
    .tc_o(tc_w), .req_o(req_w)
  );

  dma_mode_bank u_modes (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ofs(ofs), .wr_data(wr_data),
    .mode_o(mode_o)
  );

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (ofs)
        OFS_CMD: rd_data = {req_w, tc_w};
        OFS_REQ: rd_data = {4'b0, mask_w};
        default: rd_data = '0;
      endcase
    end
  end

  assign mask_o     = mask_w;
  assign req_o      = req_w;
  assign ff_clear_o = wr_en && (ofs == OFS_FFCLR || ofs == OFS_MRST);

  // R6
  ff_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ff_clear_o |-> (wr_en && port_ofs[2:1] == 2'b10));
endmodule

// File: tb/dma_ctl_regs_bench.sv
module dma_ctl_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [2:0] port_ofs = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [3:0] tc_set = 0, hw_req = 0;
  logic [7:0] cmd_o;
  logic [3:0] mask_o, req_o;
  logic [31:0] mode_o;
  logic ff_clear_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_cmd;
  logic [3:0] m_mask, m_sw, m_tc;
  logic [31:0] m_mode;
  string last_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_ctl_regs u_dma_ctl_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .port_ofs(port_ofs),
    .wr_data(wr_data), .rd_data(rd_data), .tc_set(tc_set), .hw_req(hw_req),
    .cmd_o(cmd_o), .mask_o(mask_o), .req_o(req_o), .mode_o(mode_o),
    .ff_clear_o(ff_clear_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [2:0] o);
    if (o == 3'd0) return {m_sw | hw_req, m_tc};
    if (o == 3'd1) return {4'b0, m_mask};
    return 8'h00;
  endfunction

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd0: return "R2";  3'd1: return "R3";  3'd2: return "R4";  3'd3: return "R5";
      3'd4: return "R6";  3'd5: return "R7";  default: return "R8";
    endcase
  endfunction

  task automatic model_update(input logic w, input logic r, input logic [2:0] o,
                              input logic [7:0] d, input logic [3:0] ts);
    logic [3:0] tcn;
    tcn = m_tc;
    if (r && o == 3'd0) tcn = 4'h0;
    if (w) begin
      case (o)
        3'd0: if (d == 8'h00 || d == 8'h04) m_cmd = d;
        3'd1: begin m_sw[d[1:0]] = d[2]; tcn[d[1:0]] = 1'b0; end
        3'd2: m_mask[d[1:0]] = d[2];
        3'd3: m_mode[d[1:0]*8 +: 8] = d;
        3'd5: begin m_mask = 4'hF; m_sw = 0; tcn = 0; m_cmd = 0; end
        3'd6: m_mask = 4'h0;
        3'd7: m_mask = d[3:0];
        default: ;
      endcase
    end
    m_tc = tcn | ts;
  endtask

  task automatic step(input logic w, input logic r, input logic [2:0] o,
                      input logic [7:0] d, input logic [3:0] ts, input logic [3:0] hw);
    string t;
    @(negedge clk);
    wr_en = w; rd_en = r; port_ofs = o; wr_data = d; tc_set = ts; hw_req = hw;
    #1;
    chk(last_tag, "cmd_o", 32'(cmd_o), 32'(m_cmd));
    chk(last_tag, "mask_o", 32'(mask_o), 32'(m_mask));
    chk(last_tag, "mode_o", mode_o, m_mode);
    chk("R11", "req_o", 32'(req_o), 32'(m_sw | hw));
    if (r) chk((o == 3'd0 && m_tc != 0) ? "R10" : "R9", "rd_data", 32'(rd_data), 32'(exp_rd(o)));
    chk("R6", "ff_clear_o", 32'(ff_clear_o), 32'(w && (o == 3'd4 || o == 3'd5)));
    t = (ts != 0) ? "R10" : (w ? tag_of(o) : "R9");
    @(posedge clk);
    model_update(w, r, o, d, ts);
    last_tag = t;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4242));
    m_cmd = 0; m_mask = 4'hF; m_sw = 0; m_tc = 0; m_mode = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    @(negedge clk); #1;
    chk("R1", "cmd", 32'(cmd_o), 0);
    chk("R1", "mask", 32'(mask_o), 32'hF);
    chk("R1", "mode", mode_o, 0);
    chk("R1", "req", 32'(req_o), 0);
    // R2 accept 0x04, reject 0x05
    step(1, 0, 3'd0, 8'h04, 0, 0);
    step(1, 0, 3'd0, 8'h05, 0, 0);
    step(1, 0, 3'd0, 8'h00, 0, 0);
    // R5 modes
    for (int c = 0; c < 4; c++) step(1, 0, 3'd3, 8'h54 | 8'(c) | 8'(c << 6), 0, 0);
    // R10 pulse, then read clears, then pulse during read wins
    step(0, 0, 3'd0, 0, 4'b1010, 0);
    step(0, 1, 3'd0, 0, 4'b0000, 4'b0001);
    step(0, 1, 3'd0, 0, 4'b0100, 0);
    step(0, 1, 3'd0, 0, 4'b0000, 0);
    // R3 request set clears tc; pulse in same cycle wins
    step(0, 0, 3'd0, 0, 4'b0011, 0);
    step(1, 0, 3'd1, 8'h04, 0, 0);
    step(1, 0, 3'd1, 8'h05, 4'b0010, 0);
    step(0, 1, 3'd0, 0, 0, 4'b1000);
    step(1, 0, 3'd1, 8'h00, 0, 0);
    // R4 / R8 masks
    step(1, 0, 3'd6, 0, 0, 0);
    step(1, 0, 3'd2, 8'h06, 0, 0);
    step(0, 1, 3'd1, 0, 0, 0);
    step(1, 0, 3'd7, 8'hF9, 0, 0);
    step(0, 1, 3'd1, 0, 0, 0);
    // R6 / R7
    step(1, 0, 3'd4, 0, 0, 0);
    step(1, 0, 3'd0, 8'h04, 4'b0001, 0);
    step(1, 0, 3'd5, 0, 0, 0);
    step(0, 1, 3'd0, 0, 0, 0);
    step(0, 1, 3'd5, 0, 0, 0);
    // random phase
    for (int i = 0; i < 1500; i++) begin
      logic w, r;
      logic [7:0] d;
      int k;
      k = $urandom_range(0, 9);
      w = (k < 6); r = (k >= 4);
      d = 8'($urandom);
      if ($urandom_range(0, 3) == 0) d = ($urandom_range(0, 1) != 0) ? 8'h04 : 8'h00;
      step(w, r, 3'($urandom), d,
           ($urandom_range(0, 4) == 0) ? 4'($urandom) : 4'h0, 4'($urandom));
    end
    step(0, 0, 0, 0, 0, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule